// File: doc/BRIEF.md
# Multi-Mode Serial Port

This block is a byte-wide serial port with four operating modes, selected by a two-bit mode input. Mode 0 is a synchronous shift-out mode. The port drives its own shift clock and moves one data bit every twelve system clocks. Mode 1 sends and receives 10-bit asynchronous frames. Modes 2 and 3 carry 11-bit asynchronous frames, in which a ninth data bit is placed before the stop bit. In the asynchronous modes every bit lasts sixteen sub-ticks. In mode 2 the sub-ticks come from a fixed divide-by-four of the clock, which gives a bit every 64 clocks. In modes 1 and 3 each sub-tick is one overflow pulse from an external timer.

Software loads a byte while the transmitter is idle, and it reads received bytes from a holding register. A transmit-done flag and a receive-done flag each stay set until software clears them. The receiver rejects start bits that do not hold low. It decides each bit by a majority of three samples taken around the bit centre. It can also filter frames, so that only address frames (ninth bit high) raise the receive flag. This is how a node on a shared multi-drop line ignores traffic meant for other nodes.

Top module: `sport_top`

## Requirements
- R1: After reset, txd_o and sclk_o are high, ti_o, ri_o and tx_busy_o are low, and rx_data_o is 0x00.
- R2: In mode 0 (mode_i=0), a load shifts the 8 data bits out on txd_o, LSB first, each for 12 clocks. sclk_o is low for the first 6 clocks of each bit and high for the last 6. ti_o sets and tx_busy_o drops when the eighth bit ends.
- R3: In mode 1 (mode_i=1), the frame on txd_o is a low start bit, 8 data bits LSB first, then a high stop bit. In modes 1 and 3, each bit lasts 16 tovf_i pulses.
- R4: In modes 2 and 3 (mode_i=2 or 3), the frame is a start bit, 8 data bits LSB first, tx_bit9_i, then a stop bit. In mode 2 each bit lasts 64 clocks, whatever tovf_i does.
- R5: A tx_load_i pulse while tx_busy_o is high is ignored, and the frame in progress continues unchanged.
- R6: ti_o and ri_o stay set until their clear input is pulsed, and each clears on that pulse.
- R7: Each received bit is the majority of three samples taken at sub-ticks 7, 8 and 9 of the bit. A disturbance covering a single sample does not change the received byte.
- R8: A low level on rxd_i that has returned high by the start-bit vote is discarded as a false start: ri_o stays low, rx_data_o keeps its value, and the receiver is ready for the next frame.
- R9: In mode 1, the received byte goes to rx_data_o, the stop-bit value goes to rx_bit9_o, and ri_o sets during the stop bit.
- R10: In modes 2 and 3, rx_bit9_o receives the ninth bit. While addr_filt_i is high, a frame whose ninth bit is 0 leaves ri_o and rx_data_o unchanged, and a frame whose ninth bit is 1 is accepted.
- R11: A frame that completes while ri_o is still set is dropped, and rx_data_o keeps the earlier byte.
- R12: No reception takes place while rx_en_i is low or while mode 0 is selected.
- R13: sclk_o stays high whenever no mode-0 transmission is in progress, including during asynchronous frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 0 sync shift, 1 async 8-bit, 2 async 9-bit fixed rate, 3 async 9-bit timer rate |
| tovf_i | input | 1 | Timer overflow pulse, one sub-tick in modes 1 and 3 |
| tx_load_i | input | 1 | Start a transmission with tx_data_i |
| tx_data_i | input | 8 | Byte to transmit |
| tx_bit9_i | input | 1 | Ninth bit for modes 2 and 3 |
| ti_clr_i | input | 1 | Clear the transmit-done flag |
| txd_o | output | 1 | Serial data out |
| sclk_o | output | 1 | Shift clock in mode 0, otherwise high |
| tx_busy_o | output | 1 | Frame in progress |
| ti_o | output | 1 | Transmit-done flag |
| rx_en_i | input | 1 | Receiver enable |
| addr_filt_i | input | 1 | Accept only frames whose ninth bit is 1 |
| rxd_i | input | 1 | Serial data in |
| ri_clr_i | input | 1 | Clear the receive-done flag |
| rx_data_o | output | 8 | Last accepted byte |
| rx_bit9_o | output | 1 | Ninth bit, or stop bit in mode 1, of the last accepted frame |
| ri_o | output | 1 | Receive-done flag |

## Verification
The hardest case to reach from the ports is the three-sample vote. A line disturbance has to corrupt exactly one of the three samples, but the phase of the sub-tick divider against the incoming edge is unknown. The stimulus therefore holds a bit inverted for one sub-tick period, starting at the bit centre. Whatever the divider phase, a window of that length contains exactly one sample instant. A second directed case sends a short low pulse that has returned high before the votes. This shows the false start is dropped, and a valid frame that follows shows the receiver has returned to idle.

// File: rtl/sport_pkg.sv
package sport_pkg;
  typedef enum logic [1:0] {
    MODE_SYNC    = 2'd0,
    MODE_ASYNC8  = 2'd1,
    MODE_ASYNC9F = 2'd2,
    MODE_ASYNC9T = 2'd3
  } sp_mode_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/sport_tick.sv
module sport_tick import sport_pkg::*; #(
  parameter int FIX_DIV  = 64,
  parameter int SUBTICKS = 16
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  sp_mode_e mode_i,
  input  logic     tovf_i,
  output logic     tick_o
);
  localparam int PRE = FIX_DIV / SUBTICKS;

  logic fix_tick;

  generate
    if (PRE > 1) begin : g_div
      localparam int CW = $clog2(PRE);
      localparam logic [CW-1:0] CNT_LAST = CW'(PRE - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
      end
      assign fix_tick = (cnt_q == CNT_LAST);
    end else begin : g_nodiv
      assign fix_tick = 1'b1;
    end
  endgenerate

  assign tick_o = (mode_i == MODE_ASYNC9F) ? fix_tick : tovf_i;
endmodule

// File: rtl/sport_tx.sv
module sport_tx import sport_pkg::*; #(
  parameter int SYNC_DIV = 12,
  parameter int SUBTICKS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  sp_mode_e   mode_i,
  input  logic       tick_i,
  input  logic       load_i,
  input  logic [7:0] data_i,
  input  logic       bit9_i,
  input  logic       clr_i,
  output logic       txd_o,
  output logic       sclk_o,
  output logic       busy_o,
  output logic       flag_o
);
  localparam int PW = $clog2(SYNC_DIV);
  localparam int SW = $clog2(SUBTICKS);
  localparam logic [PW-1:0] PH_LAST  = PW'(SYNC_DIV - 1);
  localparam logic [PW-1:0] PH_HALF  = PW'(SYNC_DIV / 2);
  localparam logic [SW-1:0] SUB_LAST = SW'(SUBTICKS - 1);

  logic          busy_q, sync_q, flag_q;
  logic [10:0]   sh_q;
  logic [3:0]    bcnt_q, last_q;
  logic [PW-1:0] ph_q;
  logic [SW-1:0] sub_q;
  logic          adv, done;

  assign adv  = busy_q && (sync_q ? (ph_q == PH_LAST) : (tick_i && sub_q == SUB_LAST));
  assign done = adv && (bcnt_q == last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sync_q <= 1'b0;
      sh_q   <= '1;
      bcnt_q <= '0;
      last_q <= '0;
      ph_q   <= '0;
      sub_q  <= '0;
    end else if (load_i && !busy_q) begin
      busy_q <= 1'b1;
      sync_q <= (mode_i == MODE_SYNC);
      bcnt_q <= '0;
      ph_q   <= '0;
      sub_q  <= '0;
      unique case (mode_i)
        MODE_SYNC:   begin sh_q <= {3'b111, data_i};             last_q <= 4'd7;  end
        MODE_ASYNC8: begin sh_q <= {2'b11, data_i, 1'b0};        last_q <= 4'd9;  end
        default:     begin sh_q <= {1'b1, bit9_i, data_i, 1'b0}; last_q <= 4'd10; end
      endcase
    end else if (busy_q) begin
      if (sync_q)      ph_q  <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
      else if (tick_i) sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + 1'b1;
      if (adv) begin
        sh_q   <= {1'b1, sh_q[10:1]};
        bcnt_q <= bcnt_q + 4'd1;
      end
      if (done) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (done)  flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign txd_o  = busy_q ? sh_q[0] : 1'b1;
  assign sclk_o = !(busy_q && sync_q && ph_q < PH_HALF);
  assign busy_o = busy_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/sport_rx.sv
module sport_rx import sport_pkg::*; #(
  parameter int SUBTICKS = 16,
  parameter int VOTE_AT  = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  sp_mode_e   mode_i,
  input  logic       en_i,
  input  logic       filt_i,
  input  logic       tick_i,
  input  logic       rxd_i,
  input  logic       clr_i,
  output logic [7:0] data_o,
  output logic       bit9_o,
  output logic       flag_o
);
  localparam int SW = $clog2(SUBTICKS);
  localparam logic [SW-1:0] SUB_LAST = SW'(SUBTICKS - 1);
  localparam logic [SW-1:0] SUB_ONE  = SW'(1);
  localparam logic [SW-1:0] SUB_V0   = SW'(VOTE_AT - 1);
  localparam logic [SW-1:0] SUB_V1   = SW'(VOTE_AT);
  localparam logic [SW-1:0] SUB_V2   = SW'(VOTE_AT + 1);

  logic [1:0]    sync_q, vote_q;
  logic          rx_s, act_q, b9_q, flag_q, bit9_q;
  logic [SW-1:0] sub_q;
  logic [3:0]    bidx_q, last_idx;
  logic [7:0]    sh_q, data_q;
  logic          bit_v, at_vote, at_stop, cand, keep;

  assign rx_s     = sync_q[1];
  assign last_idx = (mode_i == MODE_ASYNC8) ? 4'd9 : 4'd10;
  assign bit_v    = maj3(vote_q[0], vote_q[1], rx_s);
  assign at_vote  = act_q && tick_i && (sub_q == SUB_V2);
  assign at_stop  = at_vote && (bidx_q == last_idx);
  // mode 1 qualifies on the stop bit, 9-bit modes on the address marker
  assign cand     = (mode_i == MODE_ASYNC8) ? bit_v : b9_q;
  assign keep     = at_stop && !flag_q && (!filt_i || cand);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      vote_q <= 2'b11;
      act_q  <= 1'b0;
      sub_q  <= '0;
      bidx_q <= '0;
      sh_q   <= '0;
      b9_q   <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rxd_i};
      if (!act_q) begin
        if (tick_i && en_i && mode_i != MODE_SYNC && !rx_s) begin
          act_q  <= 1'b1;
          sub_q  <= SUB_ONE;
          bidx_q <= '0;
        end
      end else if (tick_i) begin
        if (sub_q == SUB_LAST) begin
          sub_q  <= '0;
          bidx_q <= bidx_q + 4'd1;
        end else begin
          sub_q <= sub_q + 1'b1;
        end
        if (sub_q == SUB_V0) vote_q[0] <= rx_s;
        if (sub_q == SUB_V1) vote_q[1] <= rx_s;
        if (sub_q == SUB_V2) begin
          if (bidx_q == 4'd0) begin
            if (bit_v) act_q <= 1'b0;
          end else if (bidx_q < 4'd9) begin
            sh_q <= {bit_v, sh_q[7:1]};
          end else if (bidx_q != last_idx) begin
            b9_q <= bit_v;
          end
          if (bidx_q == last_idx) act_q <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      bit9_q <= 1'b0;
      flag_q <= 1'b0;
    end else if (keep) begin
      data_q <= sh_q;
      bit9_q <= cand;
      flag_q <= 1'b1;
    end else if (clr_i) begin
      flag_q <= 1'b0;
    end
  end

  assign data_o = data_q;
  assign bit9_o = bit9_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/sport_top.sv
module sport_top import sport_pkg::*; #(
  parameter int SYNC_DIV = 12,
  parameter int FIX_DIV  = 64,
  parameter int SUBTICKS = 16,
  parameter int VOTE_AT  = SUBTICKS / 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       tovf_i,
  input  logic       tx_load_i,
  input  logic [7:0] tx_data_i,
  input  logic       tx_bit9_i,
  input  logic       ti_clr_i,
  output logic       txd_o,
  output logic       sclk_o,
  output logic       tx_busy_o,
  output logic       ti_o,
  input  logic       rx_en_i,
  input  logic       addr_filt_i,
  input  logic       rxd_i,
  input  logic       ri_clr_i,
  output logic [7:0] rx_data_o,
  output logic       rx_bit9_o,
  output logic       ri_o
);
  sp_mode_e mode;
  logic     tick;

  assign mode = sp_mode_e'(mode_i);

  sport_tick #(.FIX_DIV(FIX_DIV), .SUBTICKS(SUBTICKS)) u_tick (
    .clk_i, .rst_ni, .mode_i(mode), .tovf_i, .tick_o(tick)
  );

  sport_tx #(.SYNC_DIV(SYNC_DIV), .SUBTICKS(SUBTICKS)) u_tx (
    .clk_i, .rst_ni, .mode_i(mode), .tick_i(tick),
    .load_i(tx_load_i), .data_i(tx_data_i), .bit9_i(tx_bit9_i), .clr_i(ti_clr_i),
    .txd_o, .sclk_o, .busy_o(tx_busy_o), .flag_o(ti_o)
  );

  sport_rx #(.SUBTICKS(SUBTICKS), .VOTE_AT(VOTE_AT)) u_rx (
    .clk_i, .rst_ni, .mode_i(mode), .en_i(rx_en_i), .filt_i(addr_filt_i),
    .tick_i(tick), .rxd_i, .clr_i(ri_clr_i),
    .data_o(rx_data_o), .bit9_o(rx_bit9_o), .flag_o(ri_o)
  );
endmodule

// File: rtl/sport_chk.sv
module sport_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       txd_o,
  input logic       sclk_o,
  input logic       tx_busy_o,
  input logic       ti_o,
  input logic       ti_clr_i,
  input logic       ri_o,
  input logic       ri_clr_i,
  input logic       addr_filt_i,
  input logic [7:0] rx_data_o,
  input logic       rx_bit9_o
);
  a_r1_idle_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy_o |-> txd_o);

  a_r13_sclk_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy_o |-> sclk_o);

  a_r6_ti_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ti_o && !ti_clr_i |=> ti_o);

  a_r6_ri_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ri_o && !ri_clr_i |=> ri_o);

  a_r2_ti_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ti_o) |-> $fell(tx_busy_o));

  a_r10_filter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ri_o) && addr_filt_i |-> rx_bit9_o);

  a_r11_no_overwrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ri_o && !ri_clr_i |=> $stable(rx_data_o));
endmodule

bind sport_top sport_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .txd_o(txd_o), .sclk_o(sclk_o),
  .tx_busy_o(tx_busy_o), .ti_o(ti_o), .ti_clr_i(ti_clr_i), .ri_o(ri_o),
  .ri_clr_i(ri_clr_i), .addr_filt_i(addr_filt_i), .rx_data_o(rx_data_o),
  .rx_bit9_o(rx_bit9_o)
);

// File: tb/sport_top_bench.sv
module sport_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  // {mode, data, ninth bit}
  localparam logic [10:0] TX_VEC [NVEC] = '{
    {2'd0, 8'hA5, 1'b0}, {2'd0, 8'h3C, 1'b0}, {2'd1, 8'h5A, 1'b0},
    {2'd1, 8'h01, 1'b0}, {2'd2, 8'hC3, 1'b1}, {2'd3, 8'h7E, 1'b0},
    {2'd2, 8'h80, 1'b0}
  };

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic       tovf_i = 1'b0, tx_load_i = 1'b0, tx_bit9_i = 1'b0, ti_clr_i = 1'b0;
  logic [7:0] tx_data_i = 8'h00;
  logic       rx_en_i = 1'b0, addr_filt_i = 1'b0, rxd_i = 1'b1, ri_clr_i = 1'b0;
  logic       txd_o, sclk_o, tx_busy_o, ti_o, rx_bit9_o, ri_o;
  logic [7:0] rx_data_o;
  int checks = 0, errs = 0;
  bit done = 1'b0;

  sport_top u_sport_top (
    .clk_i(clk), .rst_ni(rst_n), .mode_i, .tovf_i, .tx_load_i, .tx_data_i,
    .tx_bit9_i, .ti_clr_i, .txd_o, .sclk_o, .tx_busy_o, .ti_o, .rx_en_i,
    .addr_filt_i, .rxd_i, .ri_clr_i, .rx_data_o, .rx_bit9_o, .ri_o
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin
    @(negedge clk);
    tovf_i = ~tovf_i;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] frame_of(input logic [1:0] m, input logic [7:0] d, input logic b);
    if (m == 2'd1) return {2'b11, d, 1'b0};
    return {1'b1, b, d, 1'b0};
  endfunction

  task automatic clr_ti();
    ti_clr_i = 1'b1; @(negedge clk); ti_clr_i = 1'b0;
    chk("R6 ti cleared", ti_o, 0);
  endtask

  task automatic clr_ri();
    ri_clr_i = 1'b1; @(negedge clk); ri_clr_i = 1'b0;
    chk("R6 ri cleared", ri_o, 0);
  endtask

  task automatic tx_check(input logic [1:0] m, input logic [7:0] d, input logic b, input bit intr);
    int p, n;
    logic [10:0] f;
    mode_i = m;
    @(negedge clk);
    tx_data_i = d; tx_bit9_i = b; tx_load_i = 1'b1;
    @(negedge clk);
    tx_load_i = 1'b0;
    if (m == 2'd0) begin
      for (int k = 0; k < 8; k++)
        for (int q = 0; q < 12; q++) begin
          if (q == 3) begin
            chk("R2 mode0 data bit", txd_o, d[k]);
            chk("R2 sclk low half", sclk_o, 0);
          end
          if (q == 9) chk("R2 sclk high half", sclk_o, 1);
          @(negedge clk);
        end
    end else begin
      p = (m == 2'd2) ? 64 : 32;
      n = (m == 2'd1) ? 10 : 11;
      f = frame_of(m, d, b);
      for (int j = 0; j < p/2; j++) begin
        if (intr && j == 2) begin tx_data_i = ~d; tx_load_i = 1'b1; end
        if (intr && j == 3) tx_load_i = 1'b0;
        @(negedge clk);
      end
      for (int i = 0; i < n; i++) begin
        if (intr)            chk("R5 busy load ignored", txd_o, f[i]);
        else if (m == 2'd1)  chk("R3 mode1 frame bit", txd_o, f[i]);
        else                 chk("R4 9-bit frame bit", txd_o, f[i]);
        chk("R13 sclk high async", sclk_o, 1);
        repeat (p) @(negedge clk);
      end
    end
    chk("R2 busy dropped", tx_busy_o, 0);
    chk("R6 ti set after frame", ti_o, 1);
    repeat (5) @(negedge clk);
    chk("R6 ti held", ti_o, 1);
    clr_ti();
  endtask

  task automatic rx_send(input logic [1:0] m, input logic [7:0] d, input logic b, input int gl);
    int p, n;
    logic [10:0] f;
    mode_i = m;
    p = (m == 2'd2) ? 64 : 32;
    n = (m == 2'd1) ? 10 : 11;
    f = frame_of(m, d, b);
    for (int i = 0; i < n; i++) begin
      rxd_i = f[i];
      if (i == gl) begin
        repeat (p/2) @(negedge clk);
        rxd_i = ~f[i];
        repeat (p/16) @(negedge clk);
        rxd_i = f[i];
        repeat (p - p/2 - p/16) @(negedge clk);
      end else begin
        repeat (p) @(negedge clk);
      end
    end
    rxd_i = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 txd reset", txd_o, 1);
    chk("R1 sclk reset", sclk_o, 1);
    chk("R1 ti reset", ti_o, 0);
    chk("R1 ri reset", ri_o, 0);
    chk("R1 busy reset", tx_busy_o, 0);
    chk("R1 rx_data reset", rx_data_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < NVEC; v++)
      tx_check(TX_VEC[v][10:9], TX_VEC[v][8:1], TX_VEC[v][0], 1'b0);

    tx_check(2'd1, 8'h96, 1'b0, 1'b1);

    rx_en_i = 1'b1;
    rx_send(2'd1, 8'h3A, 1'b0, -1);
    chk("R9 mode1 ri", ri_o, 1);
    chk("R9 mode1 data", rx_data_o, 8'h3A);
    chk("R9 mode1 stop to bit9", rx_bit9_o, 1);
    clr_ri();

    rx_send(2'd2, 8'hC5, 1'b0, 3);
    chk("R7 vote ri", ri_o, 1);
    chk("R7 vote data", rx_data_o, 8'hC5);
    chk("R10 ninth bit 0", rx_bit9_o, 0);
    clr_ri();

    mode_i = 2'd2;
    rxd_i = 1'b0;
    repeat (16) @(negedge clk);
    rxd_i = 1'b1;
    repeat (800) @(negedge clk);
    chk("R8 false start no ri", ri_o, 0);
    chk("R8 false start data kept", rx_data_o, 8'hC5);
    rx_send(2'd2, 8'h11, 1'b1, -1);
    chk("R8 recovered ri", ri_o, 1);
    chk("R8 recovered data", rx_data_o, 8'h11);
    chk("R10 ninth bit 1", rx_bit9_o, 1);
    clr_ri();

    addr_filt_i = 1'b1;
    rx_send(2'd3, 8'h44, 1'b0, -1);
    chk("R10 data frame filtered ri", ri_o, 0);
    chk("R10 data frame filtered data", rx_data_o, 8'h11);
    rx_send(2'd3, 8'h27, 1'b1, -1);
    chk("R10 address frame ri", ri_o, 1);
    chk("R10 address frame data", rx_data_o, 8'h27);
    addr_filt_i = 1'b0;

    rx_send(2'd3, 8'h99, 1'b0, -1);
    chk("R11 overrun ri held", ri_o, 1);
    chk("R11 overrun data kept", rx_data_o, 8'h27);
    clr_ri();

    rx_en_i = 1'b0;
    rx_send(2'd1, 8'h55, 1'b0, -1);
    chk("R12 disabled no ri", ri_o, 0);
    chk("R12 disabled data kept", rx_data_o, 8'h27);
    rx_en_i = 1'b1;
    rx_send(2'd0, 8'h55, 1'b0, -1);
    chk("R12 mode0 no ri", ri_o, 0);
    chk("R12 mode0 data kept", rx_data_o, 8'h27);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errs++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule